// File: doc/BRIEF.md
# SIR Receive Frame Unwrapper

This block takes the byte stream of a slow-rate infrared serial receiver and turns each asynchronously framed packet back into its bare contents. Every received byte enters as a valid/byte pair. Flag bytes are dropped and escape sequences are undone, so only payload bytes leave the block. The payload includes the trailing 16-bit check field, which this block passes on without checking. Each forwarded byte carries a start marker on the first byte of a frame and a running count. Each closed frame produces a one-cycle completion pulse with the frame length and a status word.

Unwrapping runs only when the filter is enabled and either slow-rate mode or the test override is selected. In every other setting the block is a plain one-cycle pipe. A read-only flag word shows the two fixed flag values that the unwrapper uses. The controlling state machine has four states:
- IDLE: waiting for a start flag.
- OPEN: inside a frame.
- ESC: an escape byte was seen and the next byte must be restored.
- DROP: the frame was cut off for exceeding the length limit, and bytes are discarded until the next start flag.

The transitions are:
- IDLE→OPEN on a start flag.
- OPEN→OPEN on data, or on a start flag. A start flag is either ignored as extra fill or closes the open frame with a missing-end error.
- OPEN→ESC on an escape byte.
- ESC→OPEN on a restored data byte or on a start flag.
- OPEN→IDLE on an end flag, which is a normal close.
- ESC→IDLE on an end flag, which is a framing error.
- OPEN/ESC→DROP on a byte beyond the length limit.
- DROP→OPEN on a start flag.
- Any state→IDLE when filtering is switched off.

Top module: `sir_unwrap`

## Requirements
- R1: `flag_word` always reads 0xC1C0: the start flag 0xC0 in bits [7:0] and the end flag 0xC1 in bits [15:8].
- R2: `filter_on` equals `filt_en && (sir_mode || filt_test)`. While it is low, every valid input byte appears unchanged on `out_byte` with `out_valid` one cycle later, and `out_sof` and `done` stay low.
- R3: While filtering, start flags (0xC0), including repeated leading ones, and end flags (0xC1) are never forwarded. Payload bytes appear one cycle after arrival, and the first byte of each frame has `out_sof` set.
- R4: Bytes that arrive while no frame is open (state IDLE), other than 0xC0, produce no output and no completion.
- R5: The escape byte 0x7D is not forwarded. The byte that follows it is forwarded XOR 0x20.
- R6: An end flag in an open frame gives a `done` pulse one cycle later with all error bits clear and `done_len` equal to the number of bytes forwarded in that frame.
- R7: A start flag that arrives after at least one forwarded byte, or after a pending escape, gives `done` with `err_no_eof` set and the old length in `done_len`. It also opens a new frame at once.
- R8: `byte_count` is 0 after reset and after each start flag. It rises by one with every forwarded byte, so it reads 1 together with `out_sof`.
- R9: A payload byte that arrives when `max_len` bytes have already been forwarded is dropped. It gives `done` with `err_length` and `done_len` = `max_len`. All later bytes up to the next 0xC0 are discarded.
- R10: An end flag directly after 0x7D gives `done` with `err_framing` set and forwards nothing.
- R11: The error bits are nonzero only while `done` is high, and at most one of them is set.
- R12: During and directly after reset, `out_valid`, `out_sof`, `done`, `done_len`, `byte_count` and all error bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is present this cycle |
| in_byte | input | 8 | Received byte |
| sir_mode | input | 1 | Slow-rate mode selected |
| filt_en | input | 1 | Unwrapping filter enable |
| filt_test | input | 1 | Allows the filter outside slow-rate mode |
| max_len | input | 12 | Largest accepted payload length in bytes |
| flag_word | output | 16 | Fixed flag values, end flag high byte, start flag low byte |
| filter_on | output | 1 | Unwrapping is active |
| out_valid | output | 1 | Output byte is present |
| out_byte | output | 8 | Payload byte (or raw byte when bypassed) |
| out_sof | output | 1 | First payload byte of a frame |
| byte_count | output | 12 | Bytes forwarded in the current frame |
| done | output | 1 | One-cycle frame completion pulse |
| done_len | output | 12 | Length of the frame just closed |
| err_no_eof | output | 1 | Frame closed by a start flag with no end flag |
| err_length | output | 1 | Frame exceeded `max_len` |
| err_framing | output | 1 | End flag directly after an escape |

## Verification
Every result of this block is due one clock edge after the input byte that causes it. That holds for a forwarded byte with its marker and count, and for a completion pulse with its length and error bit, because all of them come from the same output register stage. The bench drives each byte on a falling edge. At the next falling edge, just before it drives the following byte, it records whatever the outputs show. Each recorded byte or completion is therefore tied to exactly one input byte. Whole sequences are then compared against lists worked out from the requirements, including the cycles where nothing is expected.

// File: rtl/sirf_pkg.sv
package sirf_pkg;
    localparam int          SIRF_BYTE_W = 8;
    localparam logic [7:0]  SIRF_BOF    = 8'hC0;
    localparam logic [7:0]  SIRF_EOF    = 8'hC1;
    localparam logic [7:0]  SIRF_ESC    = 8'h7D;
    localparam logic [7:0]  SIRF_FLIP   = 8'h20;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPEN = 2'd1,
        ST_ESC  = 2'd2,
        ST_DROP = 2'd3
    } sirf_state_e;

    typedef enum logic [1:0] {
        K_DATA = 2'd0,
        K_BOF  = 2'd1,
        K_EOF  = 2'd2,
        K_ESC  = 2'd3
    } sirf_kind_e;

    typedef struct packed {
        logic no_eof;
        logic length;
        logic framing;
    } sirf_err_t;
endpackage

// File: rtl/sirf_classify.sv
module sirf_classify
    import sirf_pkg::*;
#(
    parameter int          BYTE_W    = SIRF_BYTE_W,
    parameter logic [7:0]  BOF_CODE  = SIRF_BOF,
    parameter logic [7:0]  EOF_CODE  = SIRF_EOF,
    parameter logic [7:0]  ESC_CODE  = SIRF_ESC
) (
    input  logic [BYTE_W-1:0] byte_i,
    output sirf_kind_e        kind_o
);
    always_comb begin
        if (byte_i == BOF_CODE)      kind_o = K_BOF;
        else if (byte_i == EOF_CODE) kind_o = K_EOF;
        else if (byte_i == ESC_CODE) kind_o = K_ESC;
        else                         kind_o = K_DATA;
    end
endmodule

// File: rtl/sirf_counter.sv
module sirf_counter #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [LEN_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + LEN_W'(1);
    end
endmodule

// File: rtl/sirf_fsm.sv
module sirf_fsm
    import sirf_pkg::*;
#(
    parameter int         BYTE_W    = SIRF_BYTE_W,
    parameter int         LEN_W     = 12,
    parameter logic [7:0] FLIP_MASK = SIRF_FLIP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  sirf_kind_e        kind,
    input  logic [LEN_W-1:0]  cnt,
    input  logic [LEN_W-1:0]  max_len,
    output logic              cnt_clr,
    output logic              cnt_inc,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_sof,
    output logic              done,
    output logic [LEN_W-1:0]  done_len,
    output sirf_err_t         err
);
    sirf_state_e       state, state_d;
    logic              fwd, close, data_hit, flip;
    logic [BYTE_W-1:0] fwd_byte;
    sirf_err_t         err_d;

    // next-state and event decode
    always_comb begin
        state_d  = state;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        fwd      = 1'b0;
        fwd_byte = in_byte;
        close    = 1'b0;
        err_d    = '0;
        data_hit = 1'b0;
        flip     = 1'b0;
        if (!active) begin
            state_d = ST_IDLE;
            cnt_clr = 1'b1;
            fwd     = in_valid;
        end else if (in_valid) begin
            unique case (state)
                ST_IDLE: begin
                    if (kind == K_BOF) begin
                        state_d = ST_OPEN;
                        cnt_clr = 1'b1;
                    end
                end
                ST_OPEN: begin
                    if (kind == K_BOF) begin
                        if (cnt != '0) begin
                            close        = 1'b1;
                            err_d.no_eof = 1'b1;
                            cnt_clr      = 1'b1;
                        end
                    end else if (kind == K_EOF) begin
                        close   = 1'b1;
                        state_d = ST_IDLE;
                    end else if (kind == K_ESC) begin
                        state_d = ST_ESC;
                    end else begin
                        data_hit = 1'b1;
                    end
                end
                ST_ESC: begin
                    if (kind == K_BOF) begin
                        close        = 1'b1;
                        err_d.no_eof = 1'b1;
                        cnt_clr      = 1'b1;
                        state_d      = ST_OPEN;
                    end else if (kind == K_EOF) begin
                        close         = 1'b1;
                        err_d.framing = 1'b1;
                        state_d       = ST_IDLE;
                    end else begin
                        data_hit = 1'b1;
                        flip     = 1'b1;
                    end
                end
                ST_DROP: begin
                    if (kind == K_BOF) begin
                        state_d = ST_OPEN;
                        cnt_clr = 1'b1;
                    end
                end
            endcase
            if (data_hit) begin
                if (cnt >= max_len) begin
                    close        = 1'b1;
                    err_d.length = 1'b1;
                    state_d      = ST_DROP;
                end else begin
                    fwd      = 1'b1;
                    cnt_inc  = 1'b1;
                    fwd_byte = flip ? (in_byte ^ FLIP_MASK) : in_byte;
                    state_d  = ST_OPEN;
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
            out_sof   <= 1'b0;
            done      <= 1'b0;
            done_len  <= '0;
            err       <= '0;
        end else begin
            out_valid <= fwd;
            out_byte  <= fwd ? fwd_byte : '0;
            out_sof   <= fwd && active && (cnt == '0);
            done      <= close;
            done_len  <= close ? cnt : '0;
            err       <= err_d;
        end
    end

    AST_ERR_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (err == '0)); // R11
    AST_ONE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones(err) <= 1)); // R11
    AST_SOF_COUNT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (cnt == LEN_W'(1))); // R8
    AST_BYPASS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!active && in_valid))
        |-> (out_valid && !out_sof && !done && out_byte == $past(in_byte))); // R2
    AST_FLAG_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(active && in_valid && state == ST_OPEN && kind != K_DATA))
        |-> !out_valid); // R3
    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(active && state == ST_DROP)) |-> !out_valid); // R9
    AST_EOF_AFTER_ESC: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(active && in_valid && state == ST_ESC && kind == K_EOF))
        |-> (done && err.framing && !out_valid)); // R10
endmodule

// File: rtl/sir_unwrap.sv
module sir_unwrap
    import sirf_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             sir_mode,
    input  logic             filt_en,
    input  logic             filt_test,
    input  logic [LEN_W-1:0] max_len,
    output logic [15:0]      flag_word,
    output logic             filter_on,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic             out_sof,
    output logic [LEN_W-1:0] byte_count,
    output logic             done,
    output logic [LEN_W-1:0] done_len,
    output logic             err_no_eof,
    output logic             err_length,
    output logic             err_framing
);
    sirf_kind_e kind;
    sirf_err_t  err;
    logic       cnt_clr, cnt_inc;

    assign flag_word = {SIRF_EOF, SIRF_BOF};
    assign filter_on = filt_en && (sir_mode || filt_test);

    sirf_classify u_cls (
        .byte_i (in_byte),
        .kind_o (kind)
    );

    sirf_counter #(.LEN_W(LEN_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (byte_count)
    );

    sirf_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (filter_on),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .kind      (kind),
        .cnt       (byte_count),
        .max_len   (max_len),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .out_valid (out_valid),
        .out_byte  (out_byte),
        .out_sof   (out_sof),
        .done      (done),
        .done_len  (done_len),
        .err       (err)
    );

    assign err_no_eof  = err.no_eof;
    assign err_length  = err.length;
    assign err_framing = err.framing;

    AST_COUNT_WITHIN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_valid && $past(filter_on))
        |-> (byte_count <= $past(max_len))); // R9
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_valid && $past(filter_on) && !out_sof)
        |-> (byte_count == $past(byte_count) + LEN_W'(1))); // R8
endmodule

// File: tb/sim_sir_unwrap.sv
module sim_sir_unwrap;
    typedef logic [7:0] bq_t[$];
    typedef int         iq_t[$];

    logic        clk = 1'b0;
    logic        rst_n, in_valid, sir_mode, filt_en, filt_test;
    logic [7:0]  in_byte;
    logic [11:0] max_len;
    logic [15:0] flag_word;
    logic        filter_on, out_valid, out_sof, done;
    logic [7:0]  out_byte;
    logic [11:0] byte_count, done_len;
    logic        err_no_eof, err_length, err_framing;

    int n_chk = 0;
    int n_err = 0;

    bq_t q_b;
    iq_t q_s, q_c, q_dl, q_de;

    always #2 clk = ~clk;

    sir_unwrap u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .sir_mode(sir_mode), .filt_en(filt_en), .filt_test(filt_test),
        .max_len(max_len), .flag_word(flag_word), .filter_on(filter_on),
        .out_valid(out_valid), .out_byte(out_byte), .out_sof(out_sof),
        .byte_count(byte_count), .done(done), .done_len(done_len),
        .err_no_eof(err_no_eof), .err_length(err_length), .err_framing(err_framing)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cap();
        if (out_valid) begin
            q_b.push_back(out_byte);
            q_s.push_back(int'(out_sof));
            q_c.push_back(int'(byte_count));
        end
        if (done || err_no_eof || err_length || err_framing) begin
            q_dl.push_back(int'(done_len));
            q_de.push_back({29'd0, err_no_eof, err_length, err_framing});
        end
    endtask

    task automatic step(input bit v, input logic [7:0] b);
        @(negedge clk);
        cap();
        in_valid = v;
        in_byte  = b;
    endtask

    task automatic send(input bq_t seq);
        q_b.delete(); q_s.delete(); q_c.delete(); q_dl.delete(); q_de.delete();
        foreach (seq[i]) step(1'b1, seq[i]);
        step(1'b0, 8'h00);
        step(1'b0, 8'h00);
    endtask

    task automatic expect_bytes(input string req, input bq_t eb, input iq_t es);
        chk(q_b.size() == eb.size(), req, "byte count", q_b.size(), eb.size());
        if (q_b.size() == eb.size())
            foreach (eb[i]) begin
                chk(q_b[i] == eb[i], req, "byte", q_b[i], eb[i]);
                chk(q_s[i] == es[i], req, "sof", q_s[i], es[i]);
            end
    endtask

    // error code: 4 = no_eof, 2 = length, 1 = framing
    task automatic expect_done(input string req, input iq_t el, input iq_t ee);
        chk(q_dl.size() == el.size(), req, "done count", q_dl.size(), el.size());
        if (q_dl.size() == el.size())
            foreach (el[i]) begin
                chk(q_dl[i] == el[i], req, "done_len", q_dl[i], el[i]);
                chk(q_de[i] == ee[i], req, "errors", q_de[i], ee[i]);
            end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!out_valid && !out_sof && !done, "R12", "flags after reset", {out_valid, out_sof, done}, 0);
        chk(byte_count == 0 && done_len == 0, "R12", "counts after reset", byte_count, 0);
        chk({err_no_eof, err_length, err_framing} == 0, "R12", "errors after reset",
            {err_no_eof, err_length, err_framing}, 0);
        chk(flag_word == 16'hC1C0, "R1", "flag word", flag_word, 16'hC1C0);
    endtask

    task automatic t_basic();
        send('{8'hC0, 8'hC0, 8'h11, 8'h22, 8'h33, 8'hC1});
        expect_bytes("R3", '{8'h11, 8'h22, 8'h33}, '{1, 0, 0});
        chk(q_c.size() == 3 && q_c[0] == 1 && q_c[2] == 3, "R8", "running count",
            q_c.size() == 3 ? q_c[2] : -1, 3);
        expect_done("R6", '{3}, '{0});
        chk(byte_count == 3, "R8", "count held after close", byte_count, 3);
    endtask

    task automatic t_idle();
        send('{8'h55, 8'h66, 8'hC1, 8'h7D, 8'hC0, 8'hAA, 8'hC1});
        expect_bytes("R4", '{8'hAA}, '{1});
        expect_done("R4", '{1}, '{0});
    endtask

    task automatic t_escape();
        send('{8'hC0, 8'h7D, 8'hE0, 8'h7D, 8'h5D, 8'h44, 8'hC1});
        expect_bytes("R5", '{8'hC0, 8'h7D, 8'h44}, '{1, 0, 0});
        expect_done("R5", '{3}, '{0});
    endtask

    task automatic t_no_eof();
        send('{8'hC0, 8'h01, 8'h02, 8'hC0, 8'h03, 8'hC1});
        expect_bytes("R7", '{8'h01, 8'h02, 8'h03}, '{1, 0, 1});
        expect_done("R7", '{2, 1}, '{4, 0});
    endtask

    task automatic t_length();
        max_len = 12'd3;
        send('{8'hC0, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'hC1, 8'hC0, 8'h09, 8'hC1});
        expect_bytes("R9", '{8'h01, 8'h02, 8'h03, 8'h09}, '{1, 0, 0, 1});
        expect_done("R9", '{3, 1}, '{2, 0});
        max_len = 12'hFFF;
    endtask

    task automatic t_framing();
        send('{8'hC0, 8'hA1, 8'h7D, 8'hC1, 8'hC0, 8'hB2, 8'hC1});
        expect_bytes("R10", '{8'hA1, 8'hB2}, '{1, 1});
        expect_done("R10", '{1, 1}, '{1, 0});
    endtask

    task automatic t_bypass();
        filt_en = 1'b0;
        @(negedge clk);
        chk(filter_on == 1'b0, "R2", "filter off", filter_on, 0);
        send('{8'hC0, 8'h7D, 8'hC1});
        expect_bytes("R2", '{8'hC0, 8'h7D, 8'hC1}, '{0, 0, 0});
        expect_done("R2", '{}, '{});
        filt_en = 1'b1; sir_mode = 1'b0; filt_test = 1'b1;
        @(negedge clk);
        chk(filter_on == 1'b1, "R2", "test override on", filter_on, 1);
        send('{8'hC0, 8'h12, 8'hC1});
        expect_bytes("R2", '{8'h12}, '{1});
        filt_test = 1'b0;
        @(negedge clk);
        chk(filter_on == 1'b0, "R2", "no mode no test", filter_on, 0);
        sir_mode = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00;
        sir_mode = 1'b1; filt_en = 1'b1; filt_test = 1'b0; max_len = 12'hFFF;
        repeat (3) @(negedge clk);
        chk(!out_valid && !done && byte_count == 0, "R12", "in reset", out_valid, 0);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_idle();
        t_escape();
        t_no_eof();
        t_length();
        t_framing();
        t_bypass();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule